// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block controls an 8-bit successive-approximation conversion. It runs from a single conversion clock `clk`, and each rising edge of `clk` is a decision edge. A conversion can start in two ways. The first is a falling edge on the dedicated `start_n` pin, which is not qualified by chip select. The second is a bus read: `cs_n` and `rd_n` both go low while `start_n` is high. Both sources pass through two-flop synchronisers and an edge detector before they reach the state machine.

After a start request the sequencer puts the sample stage into hold and pulls `busy_n` low. It lets one decision edge pass unused so the sampled input can settle, then resolves one bit per edge, most significant bit first. Each trial code is presented on `dac_code`, and the external comparator answers on `cmp_ge`. At the last decision the sequencer does four things: it moves the result into the output latch `dout`, clears the working register, pulses `done` and pulls `irq_n` low. The previous result stays on `dout` for the whole conversion.

The state machine has three states:
- `ST_IDLE` is the tracking state. `ST_IDLE → ST_ALIGN` on a start request.
- `ST_ALIGN` lets `ALIGN_CYC` decision edges pass unused. `ST_ALIGN → ST_TRIAL` when that wait is over.
- `ST_TRIAL` tests one bit per cycle. `ST_TRIAL → ST_TRIAL` moves to the next lower bit. `ST_TRIAL → ST_IDLE` happens on the LSB decision.

`irq_n` is released when a read ends. The `irq_clr_n` input forces `irq_n` high asynchronously and has no effect on the conversion.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst_n` is low: `busy_n`=1, `hold`=0, `irq_n`=1, `done`=0, `dout`=0, `dac_code`=0.
- R2: Let E0 be the first rising `clk` edge that samples `start_n` low after it was high. `busy_n` goes low and `hold` goes high after edge E0+2, and not earlier.
- R3: `cs_n` and `rd_n` both low while `start_n` is high starts a conversion with the same latency as R2, counted from the first edge that samples both low. The same read while `start_n` is low starts nothing.
- R4: Trials run MSB first. In a trial for bit i, `dac_code` = kept bits OR (1<<i). Bit i is kept when `cmp_ge`=1 at the decision edge. The MSB trial is first shown in the cycle after the one unused edge. With an ideal comparator the result equals the input code, for example 0x00, 0x7F, 0x80 and 0xFF.
- R5: `busy_n` stays low for exactly ALIGN_CYC+NBITS = 9 cycles. `hold` is high exactly while `busy_n` is low.
- R6: The result moves to `dout` at edge E0+11. At that edge `done` pulses high for one cycle, `irq_n` goes low, `busy_n` returns high and `dac_code` returns to 0.
- R7: `dout` keeps the previous result throughout a conversion.
- R8: A start request of either kind while `busy_n` is low is ignored. The conversion ends on its original schedule with its original result, and no new conversion follows.
- R9: `irq_clr_n` low forces `irq_n` high at once, without a clock edge. It does not change `busy_n`, `done`, `dout` or the conversion result.
- R10: When `cs_n` or `rd_n` rises to end a read, `irq_n` returns high after the second edge following the first edge that samples the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; rising edge is the decision edge |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| irq_clr_n | input | 1 | Asynchronous active-low interrupt release |
| start_n | input | 1 | Start pin; a falling edge requests a conversion |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| cmp_ge | input | 1 | Comparator: 1 when input is greater than or equal to the trial level |
| dac_code | output | NBITS | Trial code presented to the comparator ladder |
| hold | output | 1 | 1 = sample stage holds, 0 = tracks |
| busy_n | output | 1 | Low while a conversion runs |
| irq_n | output | 1 | Low after a completed conversion |
| done | output | 1 | One-cycle completion pulse |
| dout | output | NBITS | Latched result of the last conversion |

## Verification
All control inputs reach the state machine two edges after they are sampled. Busy and hold therefore change after edge E0+2, the MSB trial appears after E0+3, and the result, done and interrupt appear after E0+11. An interrupt release from a read ends after the second edge that follows the sampled release. The bench drives inputs on falling edges. It compares every output at each falling edge against a behavioural model that replays the sampled inputs from a history with the same latency. Targeted checks count the falling edges after each stimulus and expect each change exactly at the 3rd or 12th falling edge. The only asynchronous result, the interrupt release through `irq_clr_n`, is checked 1 ns after the pin is driven.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_TRIAL = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain_q[g] <= d;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sar_trigger.sv
module sar_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic start_s,
    input  logic rdsel_s,
    output logic start_req,
    output logic rd_release
);
    logic start_prev_q;
    logic rdsel_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_prev_q <= 1'b1;
            rdsel_prev_q <= 1'b0;
        end else begin
            start_prev_q <= start_s;
            rdsel_prev_q <= rdsel_s;
        end
    end

    logic pin_fall;
    logic bus_read;
    assign pin_fall   = start_prev_q & ~start_s;
    assign bus_read   = ~rdsel_prev_q & rdsel_s & start_s;
    assign start_req  = pin_fall | bus_read;
    assign rd_release = rdsel_prev_q & ~rdsel_s;
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 8,
    parameter int ALIGN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_clr_n,
    input  logic             start_req,
    input  logic             rd_release,
    input  logic             cmp_ge,
    output logic [NBITS-1:0] dac_code,
    output logic             hold,
    output logic             busy_n,
    output logic             irq_n,
    output logic             done,
    output logic [NBITS-1:0] dout
);
    localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int ALW  = (ALIGN_CYC > 1) ? $clog2(ALIGN_CYC) : 1;

    sar_state_e       state_q, state_d;
    logic [IDXW-1:0]  idx_q;
    logic [ALW-1:0]   align_q;
    logic [NBITS-1:0] sar_q;
    logic [NBITS-1:0] res_q;
    logic             done_q;
    logic             irq_n_q;

    logic [NBITS-1:0] trial;
    logic [NBITS-1:0] kept;
    logic             last_trial;
    logic             align_end;

    assign trial      = sar_q | (NBITS'(1) << idx_q);
    assign kept       = cmp_ge ? trial : sar_q;
    assign last_trial = (state_q == ST_TRIAL) && (idx_q == '0);
    assign align_end  = (align_q == ALW'(ALIGN_CYC-1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req)  state_d = ST_ALIGN;
            ST_ALIGN: if (align_end)  state_d = ST_TRIAL;
            ST_TRIAL: if (idx_q == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working register, bit index, result latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            align_q <= '0;
            sar_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_trial;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        sar_q   <= '0;
                        align_q <= '0;
                        idx_q   <= IDXW'(NBITS-1);
                    end
                end
                ST_ALIGN: align_q <= align_q + 1'b1;
                ST_TRIAL: begin
                    idx_q <= idx_q - 1'b1;
                    if (last_trial) begin
                        res_q <= kept;
                        sar_q <= '0;
                    end else begin
                        sar_q <= kept;
                    end
                end
                default: ;
            endcase
        end
    end

    // interrupt flop: asynchronous release, set low on completion
    always_ff @(posedge clk or negedge rst_n or negedge irq_clr_n) begin
        if (!rst_n)          irq_n_q <= 1'b1;
        else if (!irq_clr_n) irq_n_q <= 1'b1;
        else if (last_trial) irq_n_q <= 1'b0;
        else if (rd_release) irq_n_q <= 1'b1;
    end

    // outputs
    always_comb begin
        busy_n   = (state_q == ST_IDLE);
        hold     = (state_q != ST_IDLE);
        dac_code = (state_q == ST_TRIAL) ? trial : sar_q;
        irq_n    = irq_n_q;
        done     = done_q;
        dout     = res_q;
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int NBITS       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ALIGN_CYC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_clr_n,
    input  logic             start_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             cmp_ge,
    output logic [NBITS-1:0] dac_code,
    output logic             hold,
    output logic             busy_n,
    output logic             irq_n,
    output logic             done,
    output logic [NBITS-1:0] dout
);
    logic start_s;
    logic rdsel_s;
    logic start_req;
    logic rd_release;

    sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_start (
        .clk(clk), .rst_n(rst_n), .d(start_n), .q(start_s)
    );

    sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rd (
        .clk(clk), .rst_n(rst_n), .d(~(cs_n | rd_n)), .q(rdsel_s)
    );

    sar_trigger u_trig (
        .clk(clk), .rst_n(rst_n),
        .start_s(start_s), .rdsel_s(rdsel_s),
        .start_req(start_req), .rd_release(rd_release)
    );

    sar_engine #(.NBITS(NBITS), .ALIGN_CYC(ALIGN_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .irq_clr_n(irq_clr_n),
        .start_req(start_req), .rd_release(rd_release), .cmp_ge(cmp_ge),
        .dac_code(dac_code), .hold(hold), .busy_n(busy_n),
        .irq_n(irq_n), .done(done), .dout(dout)
    );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int NBITS     = 8,
    parameter int ALIGN_CYC = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_clr_n,
    input logic             busy_n,
    input logic             irq_n,
    input logic             done,
    input logic [NBITS-1:0] dout
);
    localparam int CONV_LEN = ALIGN_CYC + NBITS;
    localparam int CW       = $clog2(CONV_LEN + 2) + 1;

    logic [CW-1:0] low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_cnt <= '0;
        else if (!busy_n) low_cnt <= low_cnt + 1'b1;
        else              low_cnt <= '0;
    end

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (low_cnt == CW'(CONV_LEN)));

    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_n && !$past(busy_n)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_irq_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && irq_clr_n) |-> !irq_n);

    assert_dout_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && !$past(busy_n)) |-> $stable(dout));

    assert_clr_forces_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_clr_n |-> irq_n);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS), .ALIGN_CYC(ALIGN_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_clr_n(irq_clr_n),
    .busy_n(busy_n), .irq_n(irq_n), .done(done), .dout(dout)
);

// File: tb/sar_conv_seq_tb_top.sv
`timescale 1ns/1ps
module sar_conv_seq_tb_top;
    localparam int NB = 8;
    localparam int AL = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_clr_n = 1'b1;
    logic start_n = 1'b1;
    logic cs_n = 1'b1;
    logic rd_n = 1'b1;
    logic [NB-1:0] vin = '0;
    logic cmp_ge;
    logic [NB-1:0] dac_code, dout;
    logic hold, busy_n, irq_n, done;

    always #4 clk = ~clk;

    // ideal comparator
    assign cmp_ge = (vin >= dac_code);

    sar_conv_seq #(.NBITS(NB), .SYNC_STAGES(2), .ALIGN_CYC(AL)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_clr_n(irq_clr_n), .start_n(start_n),
        .cs_n(cs_n), .rd_n(rd_n), .cmp_ge(cmp_ge), .dac_code(dac_code),
        .hold(hold), .busy_n(busy_n), .irq_n(irq_n), .done(done), .dout(dout)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic hs[4];
    logic rr[4];
    int   m_cnt;
    int   m_sar, m_res;
    logic m_irq, m_done;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin hs[i] = 1'b1; rr[i] = 1'b0; end
            m_cnt = 0; m_sar = 0; m_res = 0; m_irq = 1'b1; m_done = 1'b0;
        end else begin
            logic sreq, rel;
            for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; rr[i] = rr[i-1]; end
            hs[0] = start_n;
            rr[0] = !cs_n && !rd_n;
            sreq = (hs[3] && !hs[2]) || (!rr[3] && rr[2] && hs[2]);
            rel  = rr[3] && !rr[2];
            m_done = 1'b0;
            if (m_cnt == 0) begin
                if (sreq) begin m_cnt = 1; m_sar = 0; end
            end else if (m_cnt <= AL) begin
                m_cnt++;
            end else begin
                int idx, tr;
                idx = AL + NB - m_cnt;
                tr  = m_sar | (1 << idx);
                if (int'(vin) >= tr) m_sar = tr;
                if (idx == 0) begin
                    m_res = m_sar; m_sar = 0; m_cnt = 0; m_done = 1'b1;
                end else begin
                    m_cnt++;
                end
            end
            if (m_done)      m_irq = 1'b0;
            else if (rel)    m_irq = 1'b1;
            if (!irq_clr_n)  m_irq = 1'b1;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int ecode;
            ecode = (m_cnt > AL) ? (m_sar | (1 << (AL + NB - m_cnt))) : m_sar;
            check("R5", "busy_n", busy_n, (m_cnt == 0));
            check("R5", "hold", hold, (m_cnt != 0));
            check("R4", "dac_code", dac_code, ecode);
            check("R6", "done", done, m_done);
            check("R6", "dout", dout, m_res);
            check("R10", "irq_n", irq_n, irq_clr_n ? m_irq : 1'b1);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic pin_conv(input logic [NB-1:0] v, input logic [NB-1:0] old,
                            input bit glitch, input bit clrpulse);
        int got;
        got = 0;
        vin = v; start_n = 1'b1;
        repeat (4) @(negedge clk);
        start_n = 1'b0;
        for (int j = 1; j <= 16; j++) begin
            @(negedge clk);
            if (j == 2) check("R2", "busy_n before E0+2", busy_n, 1'b1);
            if (j == 3) begin
                check("R2", "busy_n after E0+2", busy_n, 1'b0);
                check("R2", "hold after E0+2", hold, 1'b1);
            end
            if (j == 6) check("R7", "dout during conversion", dout, old);
            if (glitch && j == 5) start_n = 1'b1;
            if (glitch && j == 6) start_n = 1'b0;
            if (clrpulse && j == 7) begin
                #2 irq_clr_n = 1'b0;
                #1 check("R9", "irq_n async release", irq_n, 1'b1);
            end
            if (clrpulse && j == 9) irq_clr_n = 1'b1;
            if (done === 1'b1 && got == 0) got = j;
        end
        check("R6", "completion falling-edge index", got, 12);
        check("R4", "result", dout, v);
        check("R6", "irq_n after completion", irq_n, 1'b0);
        if (glitch) check("R8", "busy_n after ignored restart", busy_n, 1'b1);
        if (clrpulse) check("R9", "result with release pulse", dout, v);
    endtask

    task automatic rd_conv(input logic [NB-1:0] v, input logic [NB-1:0] old);
        int got;
        got = 0;
        vin = v; start_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        for (int j = 1; j <= 14; j++) begin
            @(negedge clk);
            if (j == 2) check("R3", "busy_n before E0+2", busy_n, 1'b1);
            if (j == 3) check("R3", "busy_n after E0+2", busy_n, 1'b0);
            if (j == 6) check("R7", "dout during read conversion", dout, old);
            if (done === 1'b1 && got == 0) got = j;
        end
        check("R3", "completion index", got, 12);
        check("R4", "read-start result", dout, v);
        check("R8", "held read does not restart", busy_n, 1'b1);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10", "irq_n before release latency", irq_n, 1'b0);
        @(negedge clk);
        check("R10", "irq_n after release", irq_n, 1'b1);
    endtask

    task automatic rd_blocked();
        cs_n = 1'b0; rd_n = 1'b0;
        for (int j = 1; j <= 14; j++) begin
            @(negedge clk);
            check("R3", "no start while start_n low", busy_n, 1'b1);
        end
        check("R10", "irq_n held while read active", irq_n, 1'b0);
        cs_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R10", "irq_n two edges into release", irq_n, 1'b0);
        @(negedge clk);
        check("R10", "irq_n released", irq_n, 1'b1);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy_n", busy_n, 1'b1);
        check("R1", "hold", hold, 1'b0);
        check("R1", "irq_n", irq_n, 1'b1);
        check("R1", "done", done, 1'b0);
        check("R1", "dout", dout, 0);
        check("R1", "dac_code", dac_code, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        pin_conv(8'hA5, 8'h00, 1'b0, 1'b0);
        rd_blocked();
        pin_conv(8'h3C, 8'hA5, 1'b1, 1'b0);   // R8 restart attempt
        pin_conv(8'h00, 8'h3C, 1'b0, 1'b1);   // R9 release pulse mid-conversion
        rd_conv(8'hFF, 8'h00);
        pin_conv(8'h80, 8'hFF, 1'b0, 1'b0);
        rd_conv(8'h7F, 8'h80);
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule